// File: doc/BRIEF.md
# Coprocessor Host Interrupt and DMA-Request Controller

This block sits on the slave side of a coprocessor's host port and has two jobs. First, it collects one raw interrupt line from each of five execution units: symmetric cipher, stream cipher, hash, random source and public-key engine. It keeps these lines as sticky status bits. A per-unit mask decides which of them reach a single registered interrupt output to the host. Every unit has the same weight, and no unit wins over another.

Second, it moves 32-bit words between the host and one chosen execution unit through two queues.

- **Input path.** The host or its DMA engine writes words into the input queue. The block passes them to the selected unit at consecutive internal addresses.
- **Output path.** The block reads words from the selected unit at consecutive addresses and holds them in the output queue until the host reads them.

Each path is set up by two registers. A control register gives the unit select and the start offset. A count register gives the number of words to move.

Two level-style DMA request outputs follow queue occupancy against a threshold of eight words. They stay high for as long as the condition holds, so no per-word handshake is needed.

Top module: `hif_irq_dma_ctrl`

## Requirements
- R1: After reset the status bits and both counts are 0, all five mask bits are 1 (every unit blocked), the host interrupt is low and both DMA requests are low.
- R2: A high level on unitIrq bit u sets status bit u at the next clock edge, whatever the mask. Status is register index 0, bits [4:0]. The bit order is symmetric cipher=0, stream cipher=1, hash=2, random source=3, public key=4. A set bit stays set until cleared.
- R3: The mask is register index 1, bits [4:0], and a 1 blocks its unit. hostIrq is a register. One edge after status and mask settle, it equals the OR over all bits of status AND NOT mask, with all units treated alike.
- R4: Writing index 0 with a 1 in bit u clears status bit u, and a 0 leaves the bit unchanged. If unitIrq bit u is high in the same cycle, the bit stays set.
- R5: The count registers are index 3 (input) and index 5 (output). A write loads the word count and restarts the word index at 0. A read returns the words still to move. The count drops by one per word moved, and at 0 no further unit transfer takes place.
- R6: The control registers are index 2 (input) and index 4 (output). Each holds the unit select in bits [18:16] and the start offset in bits [7:0]. Word k of a transfer uses unit address select*256 + ((offset+k) mod 256).
- R7: A write to index 6 puts a word into the 16-entry input queue, and a write while the queue is full is dropped. Queued words go to the unit in arrival order, one per cycle, while unitInReady is high and the input count is nonzero.
- R8: While the output count is nonzero and the output queue is not full, the block reads one word per cycle from the unit. A read of index 7 returns the oldest queued word and removes it. A read of index 7 on an empty queue returns 0.
- R9: inDreq is high exactly when the input count is nonzero and the input queue has at least 8 free entries.
- R10: outDreq is high exactly when the output queue holds at least 8 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Host access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register index |
| busWdata | input | 32 | Host write data |
| busRdata | output | 32 | Host read data, same cycle |
| unitIrq | input | 5 | Raw interrupt lines from the units |
| hostIrq | output | 1 | Masked, registered interrupt to the host |
| inDreq | output | 1 | Input-side DMA request |
| outDreq | output | 1 | Output-side DMA request |
| unitInReady | input | 1 | Selected unit can accept a word |
| unitWrEn | output | 1 | Word written to the unit this cycle |
| unitWrAddr | output | 11 | Unit address for the input word |
| unitWrData | output | 32 | Input word to the unit |
| unitRdEn | output | 1 | Word read from the unit this cycle |
| unitRdAddr | output | 11 | Unit address for the output word |
| unitRdData | input | 32 | Word returned by the unit |

## Verification
Both queues drain or fill at one word per cycle, while the host touches them at most once every two cycles. Because of that, the occupancy levels where the DMA requests switch cannot be reached with plain traffic. The bench holds unitInReady low and pushes words one at a time until the input queue is full, checking inDreq across the 8-free boundary and checking that a write into a full queue is dropped. It then lets the unit drain the queue and confirms order, address wrap and the remaining count. On the output side, the bench leaves the queue unread until the engine stalls at full, then reads words off across the eight-word boundary.

// File: rtl/hif_pkg.sv
package hif_pkg;

  typedef struct packed {
    logic rdActive;
    logic wrStatus;
    logic wrMask;
    logic wrInCtrl;
    logic wrInCnt;
    logic wrOutCtrl;
    logic wrOutCnt;
    logic pushIn;
    logic popOut;
    logic inMove;
    logic outMove;
  } hifStrobe_t;

  typedef struct packed {
    logic inCntNz;
    logic outCntNz;
    logic inEmpty;
    logic inFull;
    logic outEmpty;
    logic outFull;
  } hifState_t;

  localparam logic [3:0] REG_STATUS   = 4'd0;
  localparam logic [3:0] REG_MASK     = 4'd1;
  localparam logic [3:0] REG_IN_CTRL  = 4'd2;
  localparam logic [3:0] REG_IN_CNT   = 4'd3;
  localparam logic [3:0] REG_OUT_CTRL = 4'd4;
  localparam logic [3:0] REG_OUT_CNT  = 4'd5;
  localparam logic [3:0] REG_IN_DATA  = 4'd6;
  localparam logic [3:0] REG_OUT_DATA = 4'd7;

endpackage

// File: rtl/hif_fifo.sv
module hif_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [OCC_W-1:0] occ,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [OCC_W-1:0] occQ;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occQ  <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   occQ <= occQ + 1'b1;
        2'b01:   occQ <= occQ - 1'b1;
        default: occQ <= occQ;
      endcase
    end
  end

  assign occ      = occQ;
  assign empty    = (occQ == '0);
  assign full     = (occQ == OCC_W'(DEPTH));
  assign headData = empty ? '0 : mem[rdPtr];

endmodule

// File: rtl/hif_ctrl.sv
module hif_ctrl
  import hif_pkg::*;
(
  input  logic       busSel,
  input  logic       busWr,
  input  logic [3:0] busAddr,
  input  logic       unitInReady,
  input  hifState_t  state,
  output hifStrobe_t strobe
);

  logic wrEn;
  logic rdEn;

  assign wrEn = busSel & busWr;
  assign rdEn = busSel & ~busWr;

  always_comb begin
    strobe           = '0;
    strobe.rdActive  = rdEn;
    strobe.wrStatus  = wrEn && (busAddr == REG_STATUS);
    strobe.wrMask    = wrEn && (busAddr == REG_MASK);
    strobe.wrInCtrl  = wrEn && (busAddr == REG_IN_CTRL);
    strobe.wrInCnt   = wrEn && (busAddr == REG_IN_CNT);
    strobe.wrOutCtrl = wrEn && (busAddr == REG_OUT_CTRL);
    strobe.wrOutCnt  = wrEn && (busAddr == REG_OUT_CNT);
    // full queue: the host word is dropped
    strobe.pushIn    = wrEn && (busAddr == REG_IN_DATA) && !state.inFull;
    strobe.popOut    = rdEn && (busAddr == REG_OUT_DATA) && !state.outEmpty;
    // a count reload in the same cycle takes precedence over a transfer
    strobe.inMove    = state.inCntNz && !state.inEmpty && unitInReady && !strobe.wrInCnt;
    strobe.outMove   = state.outCntNz && !state.outFull && !strobe.wrOutCnt;
  end

endmodule

// File: rtl/hif_datapath.sv
module hif_datapath
  import hif_pkg::*;
#(
  parameter int NUM_UNITS = 5,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int THRESH    = 8,
  parameter int OFF_W     = 8,
  parameter int SEL_W     = 3,
  parameter int SEL_LSB   = 16,
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int UADDR_W  = SEL_W + OFF_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hifStrobe_t           strobe,
  input  logic [3:0]           busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  input  logic [NUM_UNITS-1:0] unitIrq,
  input  logic [DATA_W-1:0]    unitRdData,
  output logic [DATA_W-1:0]    busRdata,
  output logic                 hostIrq,
  output logic                 inDreq,
  output logic                 outDreq,
  output logic [UADDR_W-1:0]   unitWrAddr,
  output logic [DATA_W-1:0]    unitWrData,
  output logic [UADDR_W-1:0]   unitRdAddr,
  output hifState_t            state,
  output logic [NUM_UNITS-1:0] statusVal,
  output logic [NUM_UNITS-1:0] maskVal,
  output logic [DATA_W-1:0]    inCnt,
  output logic [DATA_W-1:0]    outCnt,
  output logic [OCC_W-1:0]     inOcc,
  output logic [OCC_W-1:0]     outOcc
);

  logic [NUM_UNITS-1:0] statusQ;
  logic [NUM_UNITS-1:0] maskQ;
  logic                 hostIrqQ;
  logic [SEL_W-1:0]     inSel, outSel;
  logic [OFF_W-1:0]     inOff, outOff;
  logic [OFF_W-1:0]     inIdx, outIdx;
  logic [DATA_W-1:0]    inCntQ, outCntQ;
  logic [DATA_W-1:0]    outHead;
  logic                 inFull, inEmpty, outFull, outEmpty;

  // per-unit sticky status bit, write-one-to-clear, a new raise wins
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ[u] <= 1'b0;
      end else if (unitIrq[u]) begin
        statusQ[u] <= 1'b1;
      end else if (strobe.wrStatus && busWdata[u]) begin
        statusQ[u] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ    <= '1;
      hostIrqQ <= 1'b0;
    end else begin
      if (strobe.wrMask) maskQ <= busWdata[NUM_UNITS-1:0];
      hostIrqQ <= |(statusQ & ~maskQ);
    end
  end

  // input channel sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSel  <= '0;
      inOff  <= '0;
      inIdx  <= '0;
      inCntQ <= '0;
    end else begin
      if (strobe.wrInCtrl) begin
        inSel <= busWdata[SEL_LSB +: SEL_W];
        inOff <= busWdata[OFF_W-1:0];
      end
      if (strobe.wrInCnt) begin
        inCntQ <= busWdata;
        inIdx  <= '0;
      end else if (strobe.inMove) begin
        inCntQ <= inCntQ - 1'b1;
        inIdx  <= inIdx + 1'b1;
      end
    end
  end

  // output channel sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSel  <= '0;
      outOff  <= '0;
      outIdx  <= '0;
      outCntQ <= '0;
    end else begin
      if (strobe.wrOutCtrl) begin
        outSel <= busWdata[SEL_LSB +: SEL_W];
        outOff <= busWdata[OFF_W-1:0];
      end
      if (strobe.wrOutCnt) begin
        outCntQ <= busWdata;
        outIdx  <= '0;
      end else if (strobe.outMove) begin
        outCntQ <= outCntQ - 1'b1;
        outIdx  <= outIdx + 1'b1;
      end
    end
  end

  hif_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_inFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.pushIn),
    .pop      (strobe.inMove),
    .wrData   (busWdata),
    .headData (unitWrData),
    .occ      (inOcc),
    .full     (inFull),
    .empty    (inEmpty)
  );

  hif_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_outFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.outMove),
    .pop      (strobe.popOut),
    .wrData   (unitRdData),
    .headData (outHead),
    .occ      (outOcc),
    .full     (outFull),
    .empty    (outEmpty)
  );

  assign unitWrAddr = {inSel, inOff + inIdx};
  assign unitRdAddr = {outSel, outOff + outIdx};

  assign inDreq  = (inCntQ != '0) && ((OCC_W'(DEPTH) - inOcc) >= OCC_W'(THRESH));
  assign outDreq = (outOcc >= OCC_W'(THRESH));

  function automatic logic [DATA_W-1:0] ctrlWord(input logic [SEL_W-1:0] sel,
                                                 input logic [OFF_W-1:0] off);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = sel;
    w[OFF_W-1:0] = off;
    return w;
  endfunction

  always_comb begin
    busRdata = '0;
    if (strobe.rdActive) begin
      case (busAddr)
        REG_STATUS:   busRdata[NUM_UNITS-1:0] = statusQ;
        REG_MASK:     busRdata[NUM_UNITS-1:0] = maskQ;
        REG_IN_CTRL:  busRdata = ctrlWord(inSel, inOff);
        REG_IN_CNT:   busRdata = inCntQ;
        REG_OUT_CTRL: busRdata = ctrlWord(outSel, outOff);
        REG_OUT_CNT:  busRdata = outCntQ;
        REG_OUT_DATA: busRdata = outHead;
        default:      busRdata = '0;
      endcase
    end
  end

  assign state.inCntNz  = (inCntQ != '0);
  assign state.outCntNz = (outCntQ != '0);
  assign state.inEmpty  = inEmpty;
  assign state.inFull   = inFull;
  assign state.outEmpty = outEmpty;
  assign state.outFull  = outFull;

  assign hostIrq   = hostIrqQ;
  assign statusVal = statusQ;
  assign maskVal   = maskQ;
  assign inCnt     = inCntQ;
  assign outCnt    = outCntQ;

endmodule

// File: rtl/hif_irq_dma_ctrl.sv
module hif_irq_dma_ctrl
  import hif_pkg::*;
#(
  parameter int NUM_UNITS = 5,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int THRESH    = 8,
  parameter int OFF_W     = 8,
  parameter int SEL_W     = 3,
  parameter int SEL_LSB   = 16,
  localparam int OCC_W    = $clog2(DEPTH + 1),
  localparam int UADDR_W  = SEL_W + OFF_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [3:0]           busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [NUM_UNITS-1:0] unitIrq,
  output logic                 hostIrq,
  output logic                 inDreq,
  output logic                 outDreq,
  input  logic                 unitInReady,
  output logic                 unitWrEn,
  output logic [UADDR_W-1:0]   unitWrAddr,
  output logic [DATA_W-1:0]    unitWrData,
  output logic                 unitRdEn,
  output logic [UADDR_W-1:0]   unitRdAddr,
  input  logic [DATA_W-1:0]    unitRdData
);

  hifStrobe_t           strobe;
  hifState_t            state;
  logic [NUM_UNITS-1:0] statusVal;
  logic [NUM_UNITS-1:0] maskVal;
  logic [DATA_W-1:0]    inCnt;
  logic [DATA_W-1:0]    outCnt;
  logic [OCC_W-1:0]     inOcc;
  logic [OCC_W-1:0]     outOcc;

  hif_ctrl u_ctrl (
    .busSel      (busSel),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .unitInReady (unitInReady),
    .state       (state),
    .strobe      (strobe)
  );

  hif_datapath #(
    .NUM_UNITS (NUM_UNITS),
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .THRESH    (THRESH),
    .OFF_W     (OFF_W),
    .SEL_W     (SEL_W),
    .SEL_LSB   (SEL_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .unitIrq    (unitIrq),
    .unitRdData (unitRdData),
    .busRdata   (busRdata),
    .hostIrq    (hostIrq),
    .inDreq     (inDreq),
    .outDreq    (outDreq),
    .unitWrAddr (unitWrAddr),
    .unitWrData (unitWrData),
    .unitRdAddr (unitRdAddr),
    .state      (state),
    .statusVal  (statusVal),
    .maskVal    (maskVal),
    .inCnt      (inCnt),
    .outCnt     (outCnt),
    .inOcc      (inOcc),
    .outOcc     (outOcc)
  );

  assign unitWrEn = strobe.inMove;
  assign unitRdEn = strobe.outMove;

endmodule

// File: rtl/hif_irq_dma_ctrl_chk.sv
module hif_irq_dma_ctrl_chk #(
  parameter int NUM_UNITS = 5,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int THRESH    = 8,
  localparam int OCC_W    = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWr,
  input logic [3:0]           busAddr,
  input logic [NUM_UNITS-1:0] unitIrq,
  input logic                 hostIrq,
  input logic                 inDreq,
  input logic                 outDreq,
  input logic                 unitWrEn,
  input logic                 unitRdEn,
  input logic [NUM_UNITS-1:0] statusVal,
  input logic [NUM_UNITS-1:0] maskVal,
  input logic [DATA_W-1:0]    inCnt,
  input logic [DATA_W-1:0]    outCnt,
  input logic [OCC_W-1:0]     inOcc,
  input logic [OCC_W-1:0]     outOcc
);

  assert_raw_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|unitIrq) |=> ((statusVal & $past(unitIrq)) == $past(unitIrq)));

  assert_irq_raise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusVal & ~maskVal)) |=> hostIrq);

  assert_irq_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusVal & ~maskVal)) |=> !hostIrq);

  assert_in_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (unitWrEn && !(busSel && busWr && busAddr == 4'd3)) |=> (inCnt == $past(inCnt) - 1'b1));

  assert_in_stop_at_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    unitWrEn |-> (inCnt != '0));

  assert_out_stop_at_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    unitRdEn |-> (outCnt != '0));

  assert_in_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    inOcc <= OCC_W'(DEPTH));

  assert_out_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    unitRdEn |-> (outOcc < OCC_W'(DEPTH)));

  assert_in_dreq_R9: assert property (@(posedge clk) disable iff (!rstN)
    inDreq |-> ((inCnt != '0) && (inOcc <= OCC_W'(DEPTH - THRESH))));

  assert_out_dreq_R10: assert property (@(posedge clk) disable iff (!rstN)
    outDreq |-> (outOcc >= OCC_W'(THRESH)));

endmodule

bind hif_irq_dma_ctrl hif_irq_dma_ctrl_chk #(
  .NUM_UNITS (NUM_UNITS),
  .DATA_W    (DATA_W),
  .DEPTH     (DEPTH),
  .THRESH    (THRESH)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .unitIrq   (unitIrq),
  .hostIrq   (hostIrq),
  .inDreq    (inDreq),
  .outDreq   (outDreq),
  .unitWrEn  (unitWrEn),
  .unitRdEn  (unitRdEn),
  .statusVal (statusVal),
  .maskVal   (maskVal),
  .inCnt     (inCnt),
  .outCnt    (outCnt),
  .inOcc     (inOcc),
  .outOcc    (outOcc)
);

// File: tb/hif_irq_dma_ctrl_tb.sv
module hif_irq_dma_ctrl_tb;

  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [4:0]  unitIrq = '0;
  logic        hostIrq, inDreq, outDreq;
  logic        unitInReady = 1'b1;
  logic        unitWrEn, unitRdEn;
  logic [10:0] unitWrAddr, unitRdAddr;
  logic [31:0] unitWrData, unitRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] rd;

  logic [10:0] logAddr [64];
  logic [31:0] logData [64];
  int logCnt = 0;

  // {mask, raised lines, expected host interrupt}
  localparam logic [10:0] IRQ_VEC [10] = '{
    {5'h1F, 5'h1F, 1'b0},
    {5'h00, 5'h01, 1'b1},
    {5'h1E, 5'h01, 1'b1},
    {5'h1D, 5'h01, 1'b0},
    {5'h0F, 5'h10, 1'b1},
    {5'h10, 5'h10, 1'b0},
    {5'h15, 5'h0A, 1'b1},
    {5'h1B, 5'h04, 1'b1},
    {5'h04, 5'h04, 1'b0},
    {5'h00, 5'h00, 1'b0}
  };

  always #(CLK_NS / 2) clk = ~clk;

  // execution unit model: returns a word derived from the address
  assign unitRdData = 32'h5A00_0000 | {21'd0, unitRdAddr};

  always @(negedge clk) begin
    if (rstN && unitWrEn && logCnt < 64) begin
      logAddr[logCnt] = unitWrAddr;
      logData[logCnt] = unitWrData;
      logCnt = logCnt + 1;
    end
  end

  hif_irq_dma_ctrl u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .busSel      (busSel),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .unitIrq     (unitIrq),
    .hostIrq     (hostIrq),
    .inDreq      (inDreq),
    .outDreq     (outDreq),
    .unitInReady (unitInReady),
    .unitWrEn    (unitWrEn),
    .unitWrAddr  (unitWrAddr),
    .unitWrData  (unitWrData),
    .unitRdEn    (unitRdEn),
    .unitRdAddr  (unitRdAddr),
    .unitRdData  (unitRdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    check("R1 hostIrq", 32'(hostIrq), 32'd0);
    check("R1 inDreq", 32'(inDreq), 32'd0);
    check("R1 outDreq", 32'(outDreq), 32'd0);
    busRead(4'd0, rd); check("R1 status", rd, 32'h0);
    busRead(4'd1, rd); check("R1 mask", rd, 32'h1F);
    busRead(4'd3, rd); check("R1 in count", rd, 32'h0);
    busRead(4'd5, rd); check("R1 out count", rd, 32'h0);

    // R2/R3: vector table of mask and raised lines
    for (int i = 0; i < 10; i++) begin
      busWrite(4'd1, {27'd0, IRQ_VEC[i][10:6]});
      busWrite(4'd0, 32'h1F);
      @(negedge clk); unitIrq = IRQ_VEC[i][5:1];
      @(negedge clk); unitIrq = '0;
      @(negedge clk);
      check($sformatf("R3 hostIrq vec%0d", i), 32'(hostIrq), 32'(IRQ_VEC[i][0]));
      busRead(4'd0, rd);
      check($sformatf("R2 status vec%0d", i), rd, {27'd0, IRQ_VEC[i][5:1]});
    end

    // R4: write-one-to-clear and raise-wins
    busWrite(4'd1, 32'h1F);
    busWrite(4'd0, 32'h1F);
    @(negedge clk); unitIrq = 5'h0A;
    @(negedge clk); unitIrq = '0;
    busWrite(4'd0, 32'h08);
    busRead(4'd0, rd); check("R4 partial clear", rd, 32'h02);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 4'd0; busWdata = 32'h02; unitIrq = 5'h02;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; unitIrq = '0;
    busRead(4'd0, rd); check("R4 raise wins over clear", rd, 32'h02);
    // R3: unmasking an already pending bit
    check("R3 masked pending", 32'(hostIrq), 32'd0);
    busWrite(4'd1, 32'h1D);
    @(negedge clk);
    check("R3 unmask pending", 32'(hostIrq), 32'd1);
    busWrite(4'd0, 32'h02);
    idle(1);
    check("R3 cleared", 32'(hostIrq), 32'd0);

    // R6/R7/R5: simple input transfer, select 2, offset 5
    busWrite(4'd2, 32'h0002_0005);
    busRead(4'd2, rd); check("R6 in ctrl readback", rd, 32'h0002_0005);
    busWrite(4'd3, 32'd3);
    check("R9 dreq with count", 32'(inDreq), 32'd1);
    for (int k = 0; k < 3; k++) busWrite(4'd6, 32'h1111_0000 + k);
    idle(3);
    check("R7 words delivered", 32'(logCnt), 32'd3);
    for (int k = 0; k < 3; k++) begin
      check($sformatf("R6 in addr %0d", k), {21'd0, logAddr[k]}, 32'h200 + 5 + k);
      check($sformatf("R7 in data %0d", k), logData[k], 32'h1111_0000 + k);
    end
    busRead(4'd3, rd); check("R5 in count at zero", rd, 32'd0);
    check("R9 dreq off at zero", 32'(inDreq), 32'd0);

    // R9/R7: stalled unit, threshold and full-queue drop, offset wrap
    unitInReady = 1'b0;
    busWrite(4'd2, 32'h0001_00FE);
    busWrite(4'd3, 32'd20);
    for (int k = 0; k < 8; k++) busWrite(4'd6, 32'hD000_0000 + k);
    check("R9 dreq at 8 free", 32'(inDreq), 32'd1);
    busWrite(4'd6, 32'hD000_0008);
    check("R9 dreq at 7 free", 32'(inDreq), 32'd0);
    for (int k = 9; k < 16; k++) busWrite(4'd6, 32'hD000_0000 + k);
    busWrite(4'd6, 32'hDEAD_BEEF);
    check("R7 nothing sent while not ready", 32'(logCnt), 32'd3);
    busRead(4'd3, rd); check("R5 count held while stalled", rd, 32'd20);
    unitInReady = 1'b1;
    idle(20);
    check("R7 drained count", 32'(logCnt), 32'd19);
    for (int k = 0; k < 16; k++) begin
      check($sformatf("R6 wrap addr %0d", k), {21'd0, logAddr[3+k]},
            32'h100 + ((32'hFE + k) & 32'hFF));
      check($sformatf("R7 order %0d", k), logData[3+k], 32'hD000_0000 + k);
    end
    busRead(4'd3, rd); check("R5 remaining", rd, 32'd4);
    check("R9 dreq back on", 32'(inDreq), 32'd1);

    // R8/R10/R5: output transfer, select 4, offset 0x10
    busWrite(4'd4, 32'h0004_0010);
    busWrite(4'd5, 32'd10);
    idle(12);
    busRead(4'd5, rd); check("R5 out count at zero", rd, 32'd0);
    check("R10 dreq at 10", 32'(outDreq), 32'd1);
    for (int k = 0; k < 2; k++) begin
      busRead(4'd7, rd); check($sformatf("R8 out word %0d", k), rd, 32'h5A00_0410 + k);
    end
    check("R10 dreq at 8", 32'(outDreq), 32'd1);
    busRead(4'd7, rd); check("R8 out word 2", rd, 32'h5A00_0412);
    check("R10 dreq at 7", 32'(outDreq), 32'd0);
    for (int k = 3; k < 10; k++) begin
      busRead(4'd7, rd); check($sformatf("R8 out word %0d", k), rd, 32'h5A00_0410 + k);
    end
    busRead(4'd7, rd); check("R8 empty read", rd, 32'h0);

    // R8/R5: engine stalls at full, then refills as the host reads
    busWrite(4'd5, 32'd20);
    idle(20);
    busRead(4'd5, rd); check("R5 stalled at full", rd, 32'd4);
    check("R10 dreq full", 32'(outDreq), 32'd1);
    for (int k = 0; k < 20; k++) begin
      busRead(4'd7, rd); check($sformatf("R8 refill word %0d", k), rd, 32'h5A00_0410 + k);
    end
    busRead(4'd7, rd); check("R8 empty after refill", rd, 32'h0);
    busRead(4'd5, rd); check("R5 out count drained", rd, 32'd0);
    check("R10 dreq empty", 32'(outDreq), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule